// File: doc/BRIEF.md
# Video Pixel Word Packer with Output Queue

This block sits at the end of a scaled-video pipeline. Each cycle it may accept one pixel: three 8-bit components and a key bit. It packs pixels into 32-bit words in one of four formats:

- true-colour RGB with a replicated key byte, one pixel per word;
- dithered 15-bit RGB plus key, two pixels per word;
- 4:2:2 luma/chroma, two pixels per word;
- luma-only monochrome, four pixels per word.

Finished words go into a 16-word queue. The queue drains over a 32-bit port in one of two ways. In streaming mode a word leaves as soon as one is held. In grouped mode an external agent is asked for a grant, and on the grant the block releases a fixed run of words.

Upstream drives `pix_a`, `pix_b` and `pix_c` with the components. In RGB formats they carry R, G and B. In YUV formats `pix_a` carries luma and `pix_b` carries the chroma sample of the current pixel; upstream alternates U and V. A line-start strobe closes any partly filled word and advances the dither phase. The format may change only right after a line-start strobe. The drain mode may change only while the queue is empty.

Top module: `pix_out_packer`

## Requirements
- R1: After reset, `out_data` is 0, `out_valid` is 0, `q_empty` is 1, and `q_full`, `burst_req` and `ovf` are 0.
- R2: With `fmt`=0, each pixel forms one word {8 copies of key, R, G, B}, with B in bits 7:0.
- R3: With `fmt`=1, each pixel becomes the 16-bit value {key, R5, G5, B5} (B5 in bits 4:0). The first pixel of a word sits in bits 15:0 and the second in bits 31:16.
- R4: In `fmt`=1 each component is dithered before truncation. An offset is added, the sum saturates at 255, and bits 7:3 are kept. The offset depends on {line parity, column parity}: 00→0, 01→4, 10→6, 11→2. Column parity starts at 0 on each line-start and flips on every presented pixel. Line parity starts at 0 after reset and flips on every line-start.
- R5: With `fmt`=2, each pixel becomes {chroma, luma} in 16 bits, with luma in the low byte. Two pixels share a word, the first in bits 15:0.
- R6: With `fmt`=3, each pixel contributes its luma byte. Four pixels share a word, the first in bits 7:0 and the fourth in bits 31:24.
- R7: A `line_start` pulse pushes a partly filled word with its unused lanes at zero. It pushes nothing if no lane is filled. A pixel presented in the same cycle as `line_start` is discarded.
- R8: The queue holds 16 words in arrival order. `q_full` is 1 when 16 words are held, and `q_empty` is 1 when none are.
- R9: With `burst_mode`=0, a word pushed at a clock edge appears with `out_valid`=1 after the next edge. One word leaves per cycle while any are held.
- R10: With `burst_mode`=1, `burst_req` is 1 when at least 8 words are held and no run is in progress. A cycle with `burst_grant` and `burst_req` both high starts a run of exactly 8 words on consecutive cycles. `burst_req` stays low during the run.
- R11: A pixel presented while `q_full` is 1 is dropped, and so is a line-start word pushed while `q_full` is 1. Either event sets the sticky flag `ovf`, and `ovf_clr` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_a | input | 8 | R, or luma |
| pix_b | input | 8 | G, or chroma |
| pix_c | input | 8 | B |
| pix_key | input | 1 | Key (alpha) bit |
| line_start | input | 1 | Start of a new line; flushes a partial word |
| fmt | input | 2 | 0 RGB888+key, 1 RGB555+key, 2 YUV 4:2:2, 3 mono |
| burst_mode | input | 1 | 0 streaming drain, 1 grouped drain |
| burst_grant | input | 1 | Grant for a grouped run |
| ovf_clr | input | 1 | Clears the overflow flag |
| out_data | output | 32 | Output word |
| out_valid | output | 1 | Output word valid |
| q_full | output | 1 | Queue full |
| q_empty | output | 1 | Queue empty |
| burst_req | output | 1 | Grouped run available |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench mixes random lines in streaming mode with directed cases:

- Partial words of every format closed by line-start. A packer that left stale bits in unused lanes, or pushed an empty word, would emit wrong or extra words.
- A value of 255 at the positive dither offsets. Without saturation its 5-bit field would wrap to zero.
- In grouped mode, the seventh and eighth stored words. A wrong request threshold shows there, and a wrong counter gives runs of seven or nine words.
- Filling the queue and offering one more pixel. A design that overwrote a held word, or lost the sticky flag, would emit the wrong sixteen words or clear `ovf` early.

// File: rtl/pix_out_packer.sv
module pix_out_packer #(
  parameter int DEPTH     = 16,
  parameter int BURST_LEN = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pix_valid,
  input  logic [7:0]  pix_a,
  input  logic [7:0]  pix_b,
  input  logic [7:0]  pix_c,
  input  logic        pix_key,
  input  logic        line_start,
  input  logic [1:0]  fmt,
  input  logic        burst_mode,
  input  logic        burst_grant,
  input  logic        ovf_clr,
  output logic [31:0] out_data,
  output logic        out_valid,
  output logic        q_full,
  output logic        q_empty,
  output logic        burst_req,
  output logic        ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int BW = $clog2(BURST_LEN + 1);

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bleft;
  logic [31:0]   acc;
  logic [1:0]    lane;
  logic          col, line;

  function automatic logic [4:0] dth(input logic [7:0] v, input logic [3:0] d);
    logic [8:0] s;
    s = {1'b0, v} + {5'b0, d};
    return s[8] ? 5'h1f : s[7:3];
  endfunction

  logic [3:0] doff;
  always_comb
    case ({line, col})
      2'b00:   doff = 4'd0;
      2'b01:   doff = 4'd4;
      2'b10:   doff = 4'd6;
      default: doff = 4'd2;
    endcase

  logic [15:0] p555;
  assign p555 = {pix_key, dth(pix_a, doff), dth(pix_b, doff), dth(pix_c, doff)};

  logic [31:0] pv;
  logic [4:0]  sh;
  logic        last;
  always_comb begin
    case (fmt)
      2'd0:    begin pv = {{8{pix_key}}, pix_a, pix_b, pix_c}; sh = 5'd0;           last = 1'b1;       end
      2'd1:    begin pv = {16'b0, p555};                       sh = {lane[0], 4'b0}; last = lane[0];    end
      2'd2:    begin pv = {16'b0, pix_b, pix_a};               sh = {lane[0], 4'b0}; last = lane[0];    end
      default: begin pv = {24'b0, pix_a};                      sh = {lane, 3'b0};    last = &lane;      end
    endcase
  end

  logic take, drop, flush, push, pop, start;
  logic [31:0] word;
  assign q_full    = cnt == CW'(DEPTH);
  assign q_empty   = cnt == '0;
  assign take      = pix_valid && !line_start && !q_full;
  assign drop      = pix_valid && !line_start && q_full;
  assign flush     = line_start && lane != 2'd0;
  assign word      = take ? (acc | (pv << sh)) : acc;
  assign push      = ((take && last) || flush) && !q_full;
  assign burst_req = burst_mode && bleft == '0 && cnt >= CW'(BURST_LEN);
  assign start     = burst_req && burst_grant;
  assign pop       = burst_mode ? (start || bleft != '0) : !q_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      lane <= '0;
      col  <= 1'b0;
      line <= 1'b0;
    end else if (line_start) begin
      acc  <= '0;
      lane <= '0;
      col  <= 1'b0;
      line <= ~line;
    end else if (pix_valid) begin
      col <= ~col;
      if (take) begin
        acc  <= last ? '0 : word;
        lane <= last ? 2'd0 : lane + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      bleft     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      ovf       <= 1'b0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      cnt       <= cnt + CW'(push) - CW'(pop);
      out_valid <= pop;
      if (pop) out_data <= mem[rp];
      if (start)              bleft <= BW'(BURST_LEN - 1);
      else if (bleft != '0)   bleft <= bleft - BW'(1);
      if (drop || (flush && q_full)) ovf <= 1'b1;
      else if (ovf_clr)              ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/pix_out_packer_chk.sv
module pix_out_packer_chk (
  input logic clk,
  input logic rst_n,
  input logic burst_mode,
  input logic burst_grant,
  input logic ovf_clr,
  input logic out_valid,
  input logic q_full,
  input logic q_empty,
  input logic burst_req,
  input logic ovf
);
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(q_full && q_empty)); // R8
  AST_OUT_FROM_HELD: assert property (@(posedge clk) disable iff (!rst_n) !q_empty || burst_req == 1'b0); // R10
  AST_STREAM_DRAIN: assert property (@(posedge clk) disable iff (!rst_n) (!burst_mode && !q_empty) |=> out_valid); // R9
  AST_VALID_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n) (!q_empty == 1'b0 && !burst_mode) |=> !out_valid); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovf && !ovf_clr) |=> ovf); // R11
  AST_RUN_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n) (burst_req && !burst_grant) |=> !out_valid); // R10
  AST_REQ_ONLY_BURST: assert property (@(posedge clk) disable iff (!rst_n) burst_req |-> burst_mode); // R10
endmodule

bind pix_out_packer pix_out_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .burst_grant(burst_grant),
  .ovf_clr(ovf_clr), .out_valid(out_valid), .q_full(q_full), .q_empty(q_empty),
  .burst_req(burst_req), .ovf(ovf)
);

// File: tb/tb_pix_out_packer.sv
module tb_pix_out_packer;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, pix_valid = 1'b0, pix_key = 1'b0, line_start = 1'b0;
  logic [7:0] pix_a = '0, pix_b = '0, pix_c = '0;
  logic [1:0] fmt = '0;
  logic burst_mode = 1'b0, burst_grant = 1'b0, ovf_clr = 1'b0;
  logic [31:0] out_data;
  logic out_valid, q_full, q_empty, burst_req, ovf;

  pix_out_packer dut (.*);

  int checks = 0, errors = 0;
  logic [31:0] expq[$];
  int tagq[$];
  logic mcol = 1'b0, mline = 1'b0;
  logic [31:0] macc = '0;
  int mlane = 0;
  int tagov = 0;
  int runlen = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] d5(input logic [7:0] v, input logic ln, input logic cl);
    int off, s;
    off = (!ln && !cl) ? 0 : (!ln && cl) ? 4 : (ln && !cl) ? 6 : 2;
    s = int'(v) + off;
    if (s > 255) s = 255;
    return s[7:3];
  endfunction

  function automatic int ppw(input logic [1:0] f);
    return f == 2'd0 ? 1 : f == 2'd3 ? 4 : 2;
  endfunction

  function automatic int ftag(input logic [1:0] f);
    return f == 2'd0 ? 2 : f == 2'd1 ? 3 : f == 2'd2 ? 5 : 6;
  endfunction

  task automatic px(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c, input logic k, input bit dropped);
    logic [31:0] v;
    int w;
    pix_valid = 1'b1; pix_a = a; pix_b = b; pix_c = c; pix_key = k;
    if (!dropped) begin
      case (fmt)
        2'd0: begin v = {{8{k}}, a, b, c}; w = 32; end
        2'd1: begin v = {16'b0, k, d5(a, mline, mcol), d5(b, mline, mcol), d5(c, mline, mcol)}; w = 16; end
        2'd2: begin v = {16'b0, b, a}; w = 16; end
        default: begin v = {24'b0, a}; w = 8; end
      endcase
      macc = macc | (v << (mlane * w));
      mlane++;
      if (mlane == ppw(fmt)) begin
        expq.push_back(macc);
        tagq.push_back(tagov != 0 ? tagov : ftag(fmt));
        macc = '0; mlane = 0;
      end
    end
    mcol = ~mcol;
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  task automatic lstart(input bit with_pix);
    line_start = 1'b1;
    pix_valid = with_pix;
    if (mlane != 0) begin
      expq.push_back(macc);
      tagq.push_back(7);
    end
    macc = '0; mlane = 0; mcol = 1'b0; mline = ~mline;
    @(negedge clk);
    line_start = 1'b0;
    pix_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_valid) begin
        runlen++;
        if (expq.size() == 0) chk(1'b0, "R8 unexpected word", out_data, 32'h0);
        else begin
          logic [31:0] e;
          int t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk(out_data == e, $sformatf("R%0d word", t), out_data, e);
        end
      end else begin
        if (runlen != 0 && burst_mode) chk(runlen == 8, "R10 run length", runlen, 8);
        runlen = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1
    chk(out_data == 0 && !out_valid, "R1 out", {out_valid, out_data[30:0]}, 0);
    chk(q_empty && !q_full && !burst_req && !ovf, "R1 flags", {q_empty, q_full, burst_req, ovf}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 latency
    fmt = 2'd0;
    px(8'h11, 8'h22, 8'h33, 1'b1, 1'b0);
    chk(!out_valid && !q_empty, "R9 held one cycle", {out_valid, q_empty}, 2'b00);
    @(negedge clk);
    chk(out_valid, "R9 out next cycle", out_valid, 1);
    repeat (4) @(negedge clk);

    // random lines, streaming, R2 R3 R5 R6 R7
    for (int ln = 0; ln < 300; ln++) begin
      lstart(1'b0);
      fmt = 2'($urandom_range(0, 3));
      for (int p = 0, n = $urandom_range(1, 9); p < n; p++) begin
        px(8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 1'b0);
        if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
      end
    end
    lstart(1'b0);
    repeat (20) @(negedge clk);
    chk(expq.size() == 0 && q_empty, "R9 all drained", expq.size(), 0);

    // R7: line-start with no partial, and coincident pixel discarded
    lstart(1'b0);
    repeat (5) @(negedge clk);
    chk(q_empty && expq.size() == 0, "R7 empty flush", q_empty, 1);
    fmt = 2'd3;
    px(8'hA1, 0, 0, 0, 1'b0);
    lstart(1'b1);
    px(8'hB2, 0, 0, 0, 1'b0);
    lstart(1'b0);
    repeat (6) @(negedge clk);
    chk(expq.size() == 0, "R7 coincident pixel discarded", expq.size(), 0);

    // R4 dither saturation at every phase
    for (int k = 0; k < 2; k++) begin
      lstart(1'b0);
      fmt = 2'd1;
      tagov = 4;
      px(8'hFF, 8'hFC, 8'h07, 1'b1, 1'b0);
      px(8'hFF, 8'hFC, 8'h07, 1'b0, 1'b0);
      px(8'hFD, 8'h03, 8'hFA, 1'b1, 1'b0);
      px(8'hFE, 8'hF9, 8'h04, 1'b0, 1'b0);
      tagov = 0;
    end
    lstart(1'b0);
    repeat (8) @(negedge clk);

    // R10 grouped drain
    burst_mode = 1'b1;
    fmt = 2'd0;
    for (int i = 0; i < 7; i++) px(8'(i), 8'(i * 3), 8'(i * 7), 1'b0, 1'b0);
    @(negedge clk);
    chk(!burst_req && !out_valid, "R10 no request at 7", burst_req, 0);
    px(8'h77, 8'h88, 8'h99, 1'b1, 1'b0);
    chk(burst_req, "R10 request at 8", burst_req, 1);
    burst_grant = 1'b1;
    @(negedge clk);
    burst_grant = 1'b0;
    chk(!burst_req, "R10 request low in run", burst_req, 0);
    repeat (12) @(negedge clk);
    chk(q_empty && !burst_req, "R10 drained", {q_empty, burst_req}, 2'b10);

    // R11 overflow
    for (int i = 0; i < 16; i++) px(8'(i + 100), 8'(i), 8'(255 - i), 1'(i), 1'b0);
    chk(q_full, "R8 full at 16", q_full, 1);
    px(8'hEE, 8'hEE, 8'hEE, 1'b1, 1'b1);
    chk(ovf, "R11 overflow set", ovf, 1);
    for (int g = 0; g < 2; g++) begin
      burst_grant = 1'b1;
      @(negedge clk);
      burst_grant = 1'b0;
      repeat (10) @(negedge clk);
    end
    chk(ovf, "R11 sticky", ovf, 1);
    chk(q_empty && expq.size() == 0, "R11 dropped pixel absent", expq.size(), 0);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    chk(!ovf, "R11 cleared", ovf, 0);
    burst_mode = 1'b0;
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule